// File: doc/BRIEF.md
# Repeated-Subtraction Unsigned Divider

This block divides one unsigned operand by another, the plain way. It loads the dividend into an accumulator. It then removes the divisor from the accumulator once per clock and counts each removal, and stops when what is left is smaller than the divisor. When it stops, the count is the quotient and the accumulator holds the remainder. For integer operands the results match the `/` and `%` operators of C on unsigned values. The design uses as little logic as it can: one comparator, one subtractor, one incrementer and three registers. The cost is a run time that grows with the quotient.

A caller presents the operands and raises `start` for one cycle while `busy` is low. It then waits for the one-cycle `done` pulse. A mode input chosen at start extends the accumulator with `FRAC_W` zero bits below the dividend. The quotient then carries `FRAC_W` fractional bits, and the remainder is in units of 2^-FRAC_W. Such a run takes 2^FRAC_W times as many steps. A zero divisor does not enter the loop. It returns a fixed result at once and raises a flag.

Top module: `subtract_divider`

## Requirements
- R1: A `start` seen while `busy` is low captures the operands. With a non-zero divisor, the next cycle shows `busy` high and `quotient` equal to 0.
- R2: In integer mode (`fracMode`=0), `quotient` equals dividend / divisor and `remainder` equals dividend % divisor, both unsigned, while `done` is high.
- R3: Each subtraction takes one clock. `done` rises exactly quotient+1 clock edges after the edge that accepted `start`, and `busy` is low while `done` is high.
- R4: Whenever `done` is high for a non-zero divisor, `remainder` is less than the captured divisor.
- R5: A dividend smaller than the divisor finishes after one compare, so `done` comes one edge after the accepting edge. `quotient` is then 0 and `remainder` equals the dividend.
- R6: In fractional mode (`fracMode`=1), `quotient` equals (dividend·2^FRAC_W) / divisor, with bits FRAC_W-1..0 below the binary point. `remainder` equals (dividend·2^FRAC_W) % divisor, in the same units.
- R7: A zero divisor raises `divZero` and `done` on the edge that accepts `start`, and `busy` stays low. `quotient` is then all ones across its full width, and `remainder` is the dividend, unshifted in either mode.
- R8: A `start` raised while `busy` is high is ignored. The running division finishes with the results of its original operands, and its latency is unchanged.
- R9: `done` lasts one cycle per operation. `quotient`, `remainder` and `divZero` hold until the next accepted `start`. A `start` raised in the cycle `done` is high is accepted.
- R10: `divZero` clears when the next division with a non-zero divisor is accepted.
- R11: After reset, `busy`, `done` and `divZero` are low and `quotient` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; honoured only while busy is low |
| fracMode | input | 1 | 1 selects fractional mode for this division |
| dividend | input | DATA_W | Unsigned dividend, captured on an accepted start |
| divisor | input | DATA_W | Unsigned divisor, captured on an accepted start |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle completion pulse |
| divZero | output | 1 | The last accepted division had a zero divisor |
| quotient | output | DATA_W+FRAC_W | Subtraction count (quotient) |
| remainder | output | DATA_W | Accumulator remainder |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. `done` comes from a register and the control is already idle when it shows, so a `start` in that cycle starts the next division. The bench raises `start` with fresh operands in the very cycle it sees `done`. It reads the first result in that cycle, then checks that the second division has the right latency and result. A second pairing, a `start` during a run, is judged by the unchanged result and latency of the run in progress.

// File: rtl/subtract_divider_pkg.sv
package subtract_divider_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } divState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOp;    // normal operand load
    logic loadZero;  // zero-divisor fixed result
    logic step;      // subtract and count
  } divStrobe_t;

endpackage

// File: rtl/subtract_divider_dp.sv
module subtract_divider_dp
  import subtract_divider_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  divStrobe_t               strobe,
  input  logic                     fracMode,
  input  logic [DATA_W-1:0]        dividend,
  input  logic [DATA_W-1:0]        divisor,
  output logic                     accBelowDiv,
  output logic                     divisorIsZero,
  output logic [DATA_W+FRAC_W-1:0] count,
  output logic [DATA_W-1:0]        remainder,
  output logic [DATA_W-1:0]        heldDivisor
);

  localparam int ACC_W = DATA_W + FRAC_W;

  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  intLoad;
  logic [ACC_W-1:0]  fracLoad;
  logic [ACC_W-1:0]  divisorWide;

  assign intLoad     = ACC_W'(dividend);
  assign divisorWide = ACC_W'(heldDivisor);

  generate
    if (FRAC_W > 0) begin : g_frac
      assign fracLoad = {dividend, {FRAC_W{1'b0}}};
    end else begin : g_nofrac
      assign fracLoad = intLoad;
    end
  endgenerate

  assign divisorIsZero = (divisor == '0);
  assign accBelowDiv   = (acc < divisorWide);
  assign remainder     = acc[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc         <= '0;
      count       <= '0;
      heldDivisor <= '0;
    end else if (strobe.loadZero) begin
      acc         <= intLoad;
      count       <= '1;
      heldDivisor <= '0;
    end else if (strobe.loadOp) begin
      acc         <= fracMode ? fracLoad : intLoad;
      count       <= '0;
      heldDivisor <= divisor;
    end else if (strobe.step) begin
      acc         <= acc - divisorWide;
      count       <= count + 1'b1;
    end
  end

endmodule

// File: rtl/subtract_divider_ctrl.sv
module subtract_divider_ctrl
  import subtract_divider_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       divisorIsZero,
  input  logic       accBelowDiv,
  output divStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       divZero
);

  divState_t state, stateNext;
  logic      doneNext;
  logic      divZeroNext;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    doneNext    = 1'b0;
    divZeroNext = divZero;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (divisorIsZero) begin
            strobe.loadZero = 1'b1;
            doneNext        = 1'b1;
            divZeroNext     = 1'b1;
          end else begin
            strobe.loadOp = 1'b1;
            divZeroNext   = 1'b0;
            stateNext     = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (accBelowDiv) begin
          doneNext  = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strobe.step = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      done    <= 1'b0;
      divZero <= 1'b0;
    end else begin
      state   <= stateNext;
      done    <= doneNext;
      divZero <= divZeroNext;
    end
  end

  assign busy = (state == ST_RUN);

endmodule

// File: rtl/subtract_divider.sv
module subtract_divider
  import subtract_divider_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic                     fracMode,
  input  logic [DATA_W-1:0]        dividend,
  input  logic [DATA_W-1:0]        divisor,
  output logic                     busy,
  output logic                     done,
  output logic                     divZero,
  output logic [DATA_W+FRAC_W-1:0] quotient,
  output logic [DATA_W-1:0]        remainder
);

  divStrobe_t        strobe;
  logic              accBelowDiv;
  logic              divisorIsZero;
  logic [DATA_W-1:0] heldDivisor;

  subtract_divider_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .divisorIsZero(divisorIsZero),
    .accBelowDiv  (accBelowDiv),
    .strobe       (strobe),
    .busy         (busy),
    .done         (done),
    .divZero      (divZero)
  );

  subtract_divider_dp #(
    .DATA_W(DATA_W),
    .FRAC_W(FRAC_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .fracMode     (fracMode),
    .dividend     (dividend),
    .divisor      (divisor),
    .accBelowDiv  (accBelowDiv),
    .divisorIsZero(divisorIsZero),
    .count        (quotient),
    .remainder    (remainder),
    .heldDivisor  (heldDivisor)
  );

endmodule

// File: rtl/subtract_divider_chk.sv
module subtract_divider_chk #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     start,
  input logic [DATA_W-1:0]        divisor,
  input logic                     busy,
  input logic                     done,
  input logic                     divZero,
  input logic [DATA_W+FRAC_W-1:0] quotient,
  input logic [DATA_W-1:0]        remainder,
  input logic [DATA_W-1:0]        heldDivisor
);

  assert_accept_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && divisor != '0) |=> (busy && quotient == '0));

  assert_one_step_per_clock_R3: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || quotient == $past(quotient) + 1'b1));

  assert_done_when_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_remainder_below_R4: assert property (@(posedge clk) disable iff (!rstN)
    (done && !divZero) |-> (remainder < heldDivisor));

  assert_zero_divisor_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && divisor == '0) |=> (done && divZero && !busy && quotient == '1));

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy) |=> $stable(heldDivisor));

endmodule

bind subtract_divider subtract_divider_chk #(
  .DATA_W(DATA_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .divisor    (divisor),
  .busy       (busy),
  .done       (done),
  .divZero    (divZero),
  .quotient   (quotient),
  .remainder  (remainder),
  .heldDivisor(heldDivisor)
);

// File: tb/subtract_divider_tb.sv
module subtract_divider_tb;

  localparam int DATA_W = 32;
  localparam int FRAC_W = 12;
  localparam int Q_W    = DATA_W + FRAC_W;
  localparam int LIMIT  = 150000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              fracMode = 1'b0;
  logic [DATA_W-1:0] dividend = '0;
  logic [DATA_W-1:0] divisor = '0;
  logic              busy, done, divZero;
  logic [Q_W-1:0]    quotient;
  logic [DATA_W-1:0] remainder;

  int testCount = 0;
  int failCount = 0;
  int cycleCount = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  subtract_divider #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .fracMode(fracMode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .divZero(divZero), .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // raise start for one edge; returns at the negedge after the accepting edge
  task automatic issue(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b, input bit f);
    dividend = a; divisor = b; fracMode = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // edges from the accepting edge until done shows
  task automatic waitDone(output int lat);
    lat = 0;
    while (!done && lat < LIMIT) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic runDiv(input string req, input logic [DATA_W-1:0] a,
                        input logic [DATA_W-1:0] b, input bit f);
    longint unsigned num, q, r;
    int lat;
    num = f ? (longint'(a) << FRAC_W) : longint'(a);
    q = num / b; r = num % b;
    issue(a, b, f);
    check(busy == 1'b1 && quotient == '0, "R1", "busy/count after accept", quotient, 0);
    waitDone(lat);
    check(lat == int'(q) + 1, "R3", "latency", lat, q + 1);
    check(quotient == q, req, "quotient", quotient, q);
    check(remainder == r, req, "remainder", remainder, r);
    check(remainder < b, "R4", "remainder below divisor", remainder, b);
    check(!busy && !divZero, "R3", "busy/divZero at done", {busy, divZero}, 0);
    @(negedge clk);
  endtask

  task automatic testReset();
    check(!busy && !done && !divZero && quotient == '0, "R11", "reset state",
          {busy, done, divZero}, 0);
  endtask

  task automatic testSmallDividend();
    int lat;
    issue(32'd5, 32'd9, 1'b0);
    waitDone(lat);
    check(lat == 1, "R5", "latency small dividend", lat, 1);
    check(quotient == '0 && remainder == 32'd5, "R5", "result small dividend", remainder, 5);
    @(negedge clk);
    runDiv("R5", 32'd0, 32'd5, 1'b0);
  endtask

  task automatic testZeroDivisor(input bit f);
    issue(32'hDEADBEEF, 32'd0, f);
    check(done && divZero && !busy, "R7", "flag/done at once", {done, divZero, busy}, 3'b110);
    check(quotient == {Q_W{1'b1}}, "R7", "all-ones quotient", quotient, {Q_W{1'b1}});
    check(remainder == 32'hDEADBEEF, "R7", "dividend as remainder", remainder, 32'hDEADBEEF);
    @(negedge clk);
    check(!done && divZero, "R9", "pulse ends, flag held", {done, divZero}, 2'b01);
  endtask

  task automatic testClearFlag();
    issue(32'd20, 32'd0, 1'b0);
    @(negedge clk);
    runDiv("R10", 32'd20, 32'd7, 1'b0);
    check(!divZero, "R10", "divZero cleared", divZero, 0);
  endtask

  task automatic testBusyStart();
    int lat;
    issue(32'd1000, 32'd7, 1'b0);
    repeat (10) @(negedge clk);
    dividend = 32'd50; divisor = 32'd0; fracMode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dividend = 32'd3; divisor = 32'd1;
    waitDone(lat);
    check(lat + 11 == 143, "R8", "latency unchanged", lat + 11, 143);
    check(quotient == 142 && remainder == 6 && !divZero, "R8", "result unchanged", quotient, 142);
    @(negedge clk);
  endtask

  task automatic testBackToBack();
    int lat;
    issue(32'd20, 32'd6, 1'b0);
    waitDone(lat);
    check(quotient == 3 && remainder == 2, "R9", "first result", quotient, 3);
    dividend = 32'd30; divisor = 32'd4; fracMode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && !done, "R9", "start in done cycle accepted", {busy, done}, 2'b10);
    waitDone(lat);
    check(lat == 8 && quotient == 7 && remainder == 2, "R9", "second result", quotient, 7);
    repeat (3) @(negedge clk);
    check(!done && quotient == 7 && remainder == 2, "R9", "result held", quotient, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    runDiv("R2", 32'd1000, 32'd7, 1'b0);
    runDiv("R2", 32'd100000, 32'd1000, 1'b0);
    runDiv("R2", 32'hFFFFFFFF, 32'h10000000, 1'b0);
    runDiv("R2", 32'd9, 32'd9, 1'b0);
    runDiv("R2", 32'd5, 32'd1, 1'b0);
    testSmallDividend();
    runDiv("R6", 32'd3, 32'd2, 1'b1);
    runDiv("R6", 32'd1, 32'd3, 1'b1);
    runDiv("R6", 32'd10, 32'd4, 1'b1);
    testZeroDivisor(1'b0);
    testZeroDivisor(1'b1);
    testClearFlag();
    testBusyStart();
    testBackToBack();
    finished = 1'b1;
  end

  initial begin
    while (!finished && cycleCount < 190000) begin
      @(posedge clk);
      cycleCount++;
    end
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycleCount, 190000);
    end
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule